// File: doc/BRIEF.md
# Brown-Out Response Controller

This controller watches a digitized supply-voltage code and reacts when the rail sags. Two programmable levels form a hysteresis band. A sample under the lower (detect) level stops I/O traffic in the same cycle. The same sample puts the output drivers into their safe state, asks the clock generator for a slower frequency, and latches an error flag for software.

While the controller is in its protective state it counts cycles. If the rail does not come back within a programmable number of cycles, it escalates to a shutdown request that only a reset releases. The supply can also stay at or above the upper (recover) level for a programmable number of consecutive cycles. In that case the controller leaves the protective state and walks a gated recovery path. First it asks the I/O for recalibration and waits until calibration and PLL lock are reported together. Then it asks for protocol re-initialization. Traffic resumes only when that step completes. A fresh sag at any point in this path returns the controller to the protective state with its persistence count restarted.

The analog detector is outside this block. The supply code, both levels and both cycle limits arrive as plain inputs.

Top module: `bo_response_ctrl`

## Requirements
- R1: When `supply_code < det_level`, `io_halt`, `drv_safe` and `clk_slow_req` are high in that same cycle, with no clock edge needed. After the next edge the controller is in its protective state (or, on that edge's timeout, in shutdown).
- R2: `err_irq` goes high on the clock edge after a sample below the detect level. It then stays high until `err_clear` is sampled high on an edge where the supply is not below the detect level. Detection wins over a simultaneous clear.
- R3: If the protective state lasts `persist_lim` clock edges without the debounce completing, `shutdown_req` rises on that edge. Shutdown then holds `shutdown_req`, `io_halt` and `drv_safe` high until reset, whatever the other inputs do.
- R4: In the protective state, `supply_code >= rec_level` on `settle_lim` consecutive edges moves the controller to the recalibration phase. In that phase `recal_req` and `io_halt` are high and `drv_safe` and `clk_slow_req` are low.
- R5: A sample between the two levels has no effect in normal operation: halt, safe and error stay low. A sample equal to `det_level` counts as not below. In the protective state such a sample resets the debounce run.
- R6: The recalibration phase advances to the re-initialization phase (`reinit_req` high, `recal_req` low) only on an edge where `cal_done` and `pll_locked` are both high.
- R7: On an edge with `reinit_done` high in the re-initialization phase, the controller returns to normal. `io_halt` drops and `resume` is high for exactly one cycle.
- R8: A sample below the detect level during recalibration or re-initialization returns the controller to the protective state. The persistence count restarts from zero.
- R9: If the debounce completes on the same edge as the persistence timeout, recovery wins and no shutdown is requested.
- R10: After reset, with a healthy supply, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_code | input | VW | Digitized supply sample |
| det_level | input | VW | Detect (lower) level |
| rec_level | input | VW | Recover (upper) level |
| persist_lim | input | CW | Protective-state cycles before shutdown |
| settle_lim | input | CW | Consecutive healthy cycles before recovery |
| cal_done | input | 1 | I/O recalibration finished |
| pll_locked | input | 1 | PLL lock indication |
| reinit_done | input | 1 | Protocol re-initialization finished |
| err_clear | input | 1 | Software clear of the error flag |
| io_halt | output | 1 | Stop all I/O data transfer |
| drv_safe | output | 1 | Force output drivers to safe state |
| err_irq | output | 1 | Sticky brown-out error flag |
| clk_slow_req | output | 1 | Request reduced clock frequency |
| shutdown_req | output | 1 | Request orderly shutdown |
| recal_req | output | 1 | Request I/O recalibration |
| reinit_req | output | 1 | Request protocol re-initialization |
| resume | output | 1 | One-cycle pulse: traffic may resume |

## Verification
The bench breaks a healthy run with a sample inside the hysteresis band. A design that counted band samples as healthy would enter recalibration three cycles early. It drives calibration done without PLL lock, which a design that gated on either signal alone would accept. It sags the rail again during recalibration after the protective state has already used most of its budget. A design that kept the old persistence count would then shut down early. It also lines the debounce completion up with the timeout edge, where a design that checked the timeout first would wrongly request shutdown. Finally it holds a healthy supply and every completion input after shutdown, to catch a design that lets shutdown leak back into recovery.

// File: rtl/bo_pkg.sv
package bo_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_GUARD  = 3'd1,
    ST_RECAL  = 3'd2,
    ST_REINIT = 3'd3,
    ST_OFF    = 3'd4
  } bo_state_e;

  // Sample is strictly under the level.
  function automatic logic lvl_under(input logic [31:0] s, input logic [31:0] lvl);
    return s < lvl;
  endfunction

  // Sample is at or over the level.
  function automatic logic lvl_reach(input logic [31:0] s, input logic [31:0] lvl);
    return s >= lvl;
  endfunction

  // A count that has made cnt steps reaches lim on this step; lim of 0 acts as 1.
  function automatic logic count_done(input logic [31:0] cnt, input logic [31:0] lim);
    return ({1'b0, cnt} + 33'd1) >= {1'b0, lim};
  endfunction

endpackage

// File: rtl/bo_level_cmp.sv
module bo_level_cmp
  import bo_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] supply_code,
  input  logic [VW-1:0] det_level,
  input  logic [VW-1:0] rec_level,
  output logic          below,
  output logic          above
);

  assign below = lvl_under(32'(supply_code), 32'(det_level));
  assign above = lvl_reach(32'(supply_code), 32'(rec_level));

  // R5: with a proper band the two indications never coexist
  assert_band_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_level > det_level) |-> !(below && above));

endmodule

// File: rtl/bo_window_ctr.sv
module bo_window_ctr
  import bo_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] lim,
  output logic          hit
);

  logic [CW-1:0] cnt;

  assign hit = en && count_done(32'(cnt), 32'(lim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (en && !hit) cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/bo_seq_fsm.sv
module bo_seq_fsm
  import bo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      below,
  input  logic      deb_hit,
  input  logic      per_hit,
  input  logic      cal_done,
  input  logic      pll_locked,
  input  logic      reinit_done,
  output bo_state_e state,
  output logic      resume_q
);

  bo_state_e nxt;

  // Named events for the assertions and for review.
  logic det_evt, recov_start, timeout_evt, lock_ok, reinit_evt;

  assign det_evt     = below && (state != ST_OFF);
  assign recov_start = (state == ST_GUARD) && deb_hit;
  assign timeout_evt = (state == ST_GUARD) && per_hit && !deb_hit;
  assign lock_ok     = (state == ST_RECAL) && !below && cal_done && pll_locked;
  assign reinit_evt  = (state == ST_REINIT) && !below && reinit_done;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:    if (det_evt) nxt = ST_GUARD;
      ST_GUARD: begin
        if (recov_start)      nxt = ST_RECAL;
        else if (timeout_evt) nxt = ST_OFF;
      end
      ST_RECAL: begin
        if (det_evt)          nxt = ST_GUARD;
        else if (lock_ok)     nxt = ST_REINIT;
      end
      ST_REINIT: begin
        if (det_evt)          nxt = ST_GUARD;
        else if (reinit_evt)  nxt = ST_RUN;
      end
      ST_OFF:                 nxt = ST_OFF;
      default:                nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      resume_q <= 1'b0;
    end else begin
      state    <= nxt;
      resume_q <= reinit_evt;
    end
  end

  // R1: a sag always lands in the protective state (or shutdown on timeout)
  assert_detect_guards_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (below && state != ST_OFF) |=> (state == ST_GUARD || state == ST_OFF));

  // R3: shutdown is terminal
  assert_off_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF) |=> (state == ST_OFF));

  // R6: leaving recalibration needs calibration and lock together
  assert_lock_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REINIT && $past(state) == ST_RECAL) |-> $past(cal_done && pll_locked));

  // R7: resume only follows a completed re-initialization
  assert_resume_after_reinit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |-> ($past(state) == ST_REINIT && $past(reinit_done) && state == ST_RUN));

endmodule

// File: rtl/bo_response_ctrl.sv
module bo_response_ctrl
  import bo_pkg::*;
#(
  parameter int VW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] supply_code,
  input  logic [VW-1:0] det_level,
  input  logic [VW-1:0] rec_level,
  input  logic [CW-1:0] persist_lim,
  input  logic [CW-1:0] settle_lim,
  input  logic          cal_done,
  input  logic          pll_locked,
  input  logic          reinit_done,
  input  logic          err_clear,
  output logic          io_halt,
  output logic          drv_safe,
  output logic          err_irq,
  output logic          clk_slow_req,
  output logic          shutdown_req,
  output logic          recal_req,
  output logic          reinit_req,
  output logic          resume
);

  logic      below, above;
  logic      deb_hit, per_hit;
  logic      in_guard;
  logic      err_q;
  bo_state_e state;

  bo_level_cmp #(.VW(VW)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_code (supply_code),
    .det_level   (det_level),
    .rec_level   (rec_level),
    .below       (below),
    .above       (above)
  );

  assign in_guard = (state == ST_GUARD);

  // Persistence window: runs for the whole protective stay.
  bo_window_ctr #(.CW(CW)) u_persist (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_guard),
    .en    (in_guard),
    .lim   (persist_lim),
    .hit   (per_hit)
  );

  // Debounce window: consecutive samples at or over the recover level.
  bo_window_ctr #(.CW(CW)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_guard || !above),
    .en    (in_guard && above),
    .lim   (settle_lim),
    .hit   (deb_hit)
  );

  bo_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .below       (below),
    .deb_hit     (deb_hit),
    .per_hit     (per_hit),
    .cal_done    (cal_done),
    .pll_locked  (pll_locked),
    .reinit_done (reinit_done),
    .state       (state),
    .resume_q    (resume)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= below || (err_q && !err_clear);
  end

  assign err_irq      = err_q;
  assign io_halt      = below || (state != ST_RUN);
  assign drv_safe     = below || in_guard || (state == ST_OFF);
  assign clk_slow_req = below || in_guard;
  assign shutdown_req = (state == ST_OFF);
  assign recal_req    = (state == ST_RECAL) && !below;
  assign reinit_req   = (state == ST_REINIT) && !below;

  // R2: the flag holds unless software clears it
  assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) && !$past(err_clear)) |-> err_q);

  // R2: every sag is recorded
  assert_err_on_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    below |=> err_q);

endmodule

// File: tb/bo_response_ctrl_tb.sv
module bo_response_ctrl_tb_top;

  localparam int VW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] supply_code = 8'd200;
  logic [VW-1:0] det_level = 8'd100;
  logic [VW-1:0] rec_level = 8'd110;
  logic [CW-1:0] persist_lim = 16'd8;
  logic [CW-1:0] settle_lim = 16'd4;
  logic cal_done = 0, pll_locked = 0, reinit_done = 0, err_clear = 0;
  logic io_halt, drv_safe, err_irq, clk_slow_req, shutdown_req, recal_req, reinit_req, resume;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bo_response_ctrl #(.VW(VW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .det_level(det_level),
    .rec_level(rec_level), .persist_lim(persist_lim), .settle_lim(settle_lim),
    .cal_done(cal_done), .pll_locked(pll_locked), .reinit_done(reinit_done),
    .err_clear(err_clear), .io_halt(io_halt), .drv_safe(drv_safe), .err_irq(err_irq),
    .clk_slow_req(clk_slow_req), .shutdown_req(shutdown_req), .recal_req(recal_req),
    .reinit_req(reinit_req), .resume(resume)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    supply_code = 8'd200; cal_done = 0; pll_locked = 0; reinit_done = 0; err_clear = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  // Entry edge into guard, then n healthy edges.
  task automatic enter_guard_then_healthy(input int n);
    supply_code = 8'd90;  cyc();
    supply_code = 8'd120;
    repeat (n) cyc();
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R10", "io_halt", io_halt, 0);
    chk("R10", "drv_safe", drv_safe, 0);
    chk("R10", "err_irq", err_irq, 0);
    chk("R10", "shutdown_req", shutdown_req, 0);
    chk("R10", "recal/reinit/resume", recal_req | reinit_req | resume | clk_slow_req, 0);
  endtask

  task automatic t_hyst_normal();
    reset_dut();
    supply_code = 8'd105;
    repeat (5) cyc();
    chk("R5", "band io_halt", io_halt, 0);
    chk("R5", "band drv_safe", drv_safe, 0);
    chk("R5", "band err_irq", err_irq, 0);
    supply_code = 8'd100;
    cyc();
    chk("R5", "equal-to-detect io_halt", io_halt, 0);
    chk("R5", "equal-to-detect err_irq", err_irq, 0);
    supply_code = 8'd99;
    settle();
    chk("R1", "99 immediate io_halt", io_halt, 1);
    chk("R1", "99 immediate clk_slow_req", clk_slow_req, 1);
  endtask

  task automatic t_detect_and_recover();
    reset_dut();
    supply_code = 8'd90;
    settle();
    chk("R1", "same-cycle io_halt", io_halt, 1);
    chk("R1", "same-cycle drv_safe", drv_safe, 1);
    chk("R1", "same-cycle clk_slow_req", clk_slow_req, 1);
    cyc();
    chk("R2", "err_irq after detect", err_irq, 1);
    supply_code = 8'd120; cyc(); cyc();
    supply_code = 8'd105; cyc();
    chk("R5", "band in guard keeps drivers safe", drv_safe, 1);
    supply_code = 8'd120;
    repeat (3) cyc();
    chk("R4", "no recal before full debounce run", recal_req, 0);
    cyc();
    chk("R4", "recal_req after debounce", recal_req, 1);
    chk("R4", "io_halt in recal", io_halt, 1);
    chk("R4", "drv_safe released in recal", drv_safe, 0);
    chk("R4", "clk_slow_req released in recal", clk_slow_req, 0);
    cal_done = 1; cyc(); cyc();
    chk("R6", "recal held without lock", recal_req, 1);
    chk("R6", "no reinit without lock", reinit_req, 0);
    pll_locked = 1; cyc();
    chk("R6", "reinit_req after cal+lock", reinit_req, 1);
    chk("R6", "recal_req dropped", recal_req, 0);
    cal_done = 0; pll_locked = 0;
    cyc();
    chk("R7", "halt held during reinit", io_halt, 1);
    reinit_done = 1; cyc();
    chk("R7", "resume pulse", resume, 1);
    chk("R7", "io_halt released", io_halt, 0);
    reinit_done = 0; cyc();
    chk("R7", "resume single cycle", resume, 0);
    chk("R2", "err_irq sticky through recovery", err_irq, 1);
    supply_code = 8'd90; err_clear = 1; cyc();
    chk("R2", "clear loses to detection", err_irq, 1);
    supply_code = 8'd200; cyc();
    chk("R2", "clear with healthy supply", err_irq, 0);
    err_clear = 0;
  endtask

  task automatic t_restart_and_shutdown();
    reset_dut();
    supply_code = 8'd90;  cyc();
    supply_code = 8'd105; repeat (3) cyc();
    supply_code = 8'd120; repeat (4) cyc();
    chk("R4", "recal reached", recal_req, 1);
    supply_code = 8'd90; cyc();
    chk("R8", "recal aborted by sag", recal_req, 0);
    chk("R8", "drivers safe again", drv_safe, 1);
    repeat (7) cyc();
    chk("R8", "persistence restarted, no early shutdown", shutdown_req, 0);
    cyc();
    chk("R3", "shutdown_req on timeout", shutdown_req, 1);
    chk("R3", "io_halt in shutdown", io_halt, 1);
    chk("R3", "drv_safe in shutdown", drv_safe, 1);
    supply_code = 8'd200; cal_done = 1; pll_locked = 1; reinit_done = 1;
    repeat (5) cyc();
    chk("R3", "shutdown held", shutdown_req, 1);
    chk("R3", "drv_safe held", drv_safe, 1);
    chk("R3", "no resume from shutdown", resume, 0);
    cal_done = 0; pll_locked = 0; reinit_done = 0;
  endtask

  task automatic t_tie();
    reset_dut();
    supply_code = 8'd90;  cyc();
    supply_code = 8'd105; repeat (4) cyc();
    supply_code = 8'd120; repeat (3) cyc();
    chk("R9", "not yet recal", recal_req, 0);
    chk("R9", "not yet shutdown", shutdown_req, 0);
    cyc();
    chk("R9", "recovery wins tie", recal_req, 1);
    chk("R9", "no shutdown on tie", shutdown_req, 0);
  endtask

  task automatic t_reinit_drop();
    reset_dut();
    enter_guard_then_healthy(4);
    cal_done = 1; pll_locked = 1; cyc();
    chk("R6", "reinit reached", reinit_req, 1);
    cal_done = 0; pll_locked = 0;
    supply_code = 8'd90;
    settle();
    chk("R1", "halt on sag in reinit", io_halt, 1);
    chk("R1", "drv_safe on sag in reinit", drv_safe, 1);
    cyc();
    chk("R8", "back to guard from reinit", clk_slow_req, 1);
    chk("R8", "reinit_req dropped", reinit_req, 0);
    chk("R8", "no resume", resume, 0);
  endtask

  initial begin
    t_reset();
    t_hyst_normal();
    t_detect_and_recover();
    t_restart_and_shutdown();
    t_tie();
    t_reinit_drop();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule